// File: doc/BRIEF.md
# Cascaded Display Driver Frame Serializer

This block sits on the host side of a chain of serial-in display segment drivers. Each driver holds a 34-stage shift register and a 33-bit output latch. The host presents one 33-bit word per device as a single parallel vector and pulses `start`. The block then produces the serial clock, the serial data and, where the selected framing needs it, a load strobe. Together these refresh every device in the chain in one pass.

Three framing modes are supported. In self-load mode a leading marker bit travels to the far end of the chain. When it reaches the last device's serial output, that output loads all the latches. In the two externally loaded modes the block drives the load strobe itself, after a frame that either starts with the marker or omits it. A separator bit sits between the 33-bit groups of neighbouring devices. Its value depends on the mode.

The serial clock half-period and the load-strobe width are set at start in system cycles. Parameter floors keep the serial rate and the strobe width inside what the drivers accept. `busy` covers the whole transfer, and `done` marks its end.

Top module: `cascade_frame_tx`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `ser_clk`, `ser_dat`, `ser_load`, `busy` and `done` are all 0.
- R2: Device d, counted from 0 at the device wired to `ser_dat`, takes its word from `words[33*d +: 33]`. The word for device NDEV-1 is sent first. Each word is sent from bit 32 down to bit 0.
- R3: Mode is encoded as 0 = self-load, 1 = external load with marker, 2 or 3 = external load without marker. In modes 0 and 1 the frame is 34*NDEV bits long and its first bit is a marker of value 1.
- R4: In modes 2 and 3 the frame is 34*NDEV-1 bits long and has no marker. In every mode, one separator bit precedes each group after the first. The separator is 1 in mode 0 and 0 in the other modes.
- R5: Each bit takes a low clock phase followed by a high clock phase. Each phase lasts max(`half_div`, MIN_HALF) cycles. `ser_dat` changes only while `ser_clk` is low and stays constant for the whole high phase.
- R6: In modes 1, 2 and 3, `ser_load` rises right after the last high clock phase. It stays high for max(`load_len`, MIN_LOAD) cycles while `ser_clk` stays low.
- R7: In mode 0 `ser_load` never rises during a frame.
- R8: `busy` rises the cycle after an accepted `start` and stays high for exactly 2*H*L_frame cycles, plus the strobe width in the external modes. Here H is the effective half-period and L_frame is the frame length in bits. `done` is high for the single cycle after `busy` falls.
- R9: `start` while `busy` is ignored. Mode, words and timing are captured when a frame is accepted, so input changes during a frame have no effect.
- R10: After a frame, the output latch of every device in the chain holds the word requested for it, in each of the four mode codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame when idle |
| mode | input | 2 | Framing mode (R3) |
| words | input | NDEV*33 | Requested output word per device |
| half_div | input | CNT_W | Serial clock half-period in cycles |
| load_len | input | CNT_W | Load strobe width in cycles |
| ser_clk | output | 1 | Serial clock to the chain |
| ser_dat | output | 1 | Serial data to the first device |
| ser_load | output | 1 | Load strobe to all devices (external modes) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench chains three behavioural driver models. In self-load mode the last model's serial output drives the load input of every model. Any error in frame length or marker position therefore leaves every latch wrong. An off-by-one in the 33-bit mode shifts every group by one stage. A wrong separator value, or reversed word or device order, shows up as a mismatch against the bit stream captured at each clock rise.

Divider and strobe values below their floors are applied, so a missing clamp changes the measured high-phase and strobe cycle totals. A second `start` with different words is sent mid-frame. A design that accepts it, or that reads `words` live instead of a captured copy, ends with the wrong latch contents or an extra `done`.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int GRP_BITS   = 33;
    localparam int SLOT_BITS  = 34;
    localparam int GRP_IDX_W  = 8;
    localparam int OFF_W      = 6;

    typedef enum logic [1:0] {
        MD_SELF    = 2'd0,
        MD_EXT_MRK = 2'd1,
        MD_EXT_RAW = 2'd2,
        MD_EXT_ALT = 2'd3
    } load_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOAD = 2'd3
    } phase_e;

    // Position inside the frame: group (0 = farthest device) and slot offset.
    // Offset 0 is the separator or marker; offsets 1..33 carry bits 32..0.
    typedef struct packed {
        logic [GRP_IDX_W-1:0] grp;
        logic [OFF_W-1:0]     off;
    } slot_pos_t;

    function automatic logic has_marker(load_mode_e m);
        return (m == MD_SELF) || (m == MD_EXT_MRK);
    endfunction

    function automatic logic sep_value(load_mode_e m);
        return (m == MD_SELF);
    endfunction

    function automatic logic needs_strobe(load_mode_e m);
        return (m != MD_SELF);
    endfunction

endpackage

// File: rtl/cfs_phase_timer.sv
module cfs_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] lim,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    assign expire = en && (cnt >= lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    // R5
    phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < lim));

endmodule

// File: rtl/cfs_slot_mux.sv
module cfs_slot_mux
    import cfs_pkg::*;
#(
    parameter int NDEV = 3
) (
    input  slot_pos_t               pos,
    input  load_mode_e              mode,
    input  logic [NDEV*GRP_BITS-1:0] words,
    output logic                    bit_o
);

    logic [GRP_BITS-1:0] dev_word [NDEV];

    for (genvar d = 0; d < NDEV; d++) begin : g_word
        assign dev_word[d] = words[d*GRP_BITS +: GRP_BITS];
    end

    logic [GRP_BITS-1:0] wsel;
    logic                dsel;

    always_comb begin
        wsel = '0;
        for (int d = 0; d < NDEV; d++) begin
            if (pos.grp == GRP_IDX_W'(NDEV - 1 - d)) wsel = dev_word[d];
        end
        dsel = 1'b0;
        for (int b = 0; b < GRP_BITS; b++) begin
            if (pos.off == OFF_W'(GRP_BITS - b)) dsel = wsel[b];
        end
        if (pos.off == '0) begin
            bit_o = (pos.grp == '0) ? 1'b1 : sep_value(mode);
        end else begin
            bit_o = dsel;
        end
    end

endmodule

// File: rtl/cascade_frame_tx.sv
module cascade_frame_tx
    import cfs_pkg::*;
#(
    parameter int NDEV     = 3,
    parameter int CNT_W    = 8,
    parameter int MIN_HALF = 2,
    parameter int MIN_LOAD = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [1:0]               mode,
    input  logic [NDEV*GRP_BITS-1:0] words,
    input  logic [CNT_W-1:0]         half_div,
    input  logic [CNT_W-1:0]         load_len,
    output logic                     ser_clk,
    output logic                     ser_dat,
    output logic                     ser_load,
    output logic                     busy,
    output logic                     done
);

    localparam int WORDS_W = NDEV * GRP_BITS;
    localparam logic [CNT_W-1:0]     HALF_FLOOR = CNT_W'(MIN_HALF);
    localparam logic [CNT_W-1:0]     LOAD_FLOOR = CNT_W'(MIN_LOAD);
    localparam logic [GRP_IDX_W-1:0] LAST_GRP   = GRP_IDX_W'(NDEV - 1);
    localparam logic [OFF_W-1:0]     LAST_OFF   = OFF_W'(SLOT_BITS - 1);

    phase_e               ph;
    load_mode_e           mode_q;
    logic [WORDS_W-1:0]   words_q;
    logic [CNT_W-1:0]     half_q;
    logic [CNT_W-1:0]     load_q;
    slot_pos_t            pos;
    logic                 done_q;

    logic [CNT_W-1:0]     half_eff, load_eff, lim;
    logic                 expire, slot_bit, last_slot;
    load_mode_e           mode_in;

    assign mode_in   = load_mode_e'(mode);
    assign half_eff  = (half_div < HALF_FLOOR) ? HALF_FLOOR : half_div;
    assign load_eff  = (load_len < LOAD_FLOOR) ? LOAD_FLOOR : load_len;
    assign lim       = (ph == PH_LOAD) ? load_q : half_q;
    assign last_slot = (pos.grp == LAST_GRP) && (pos.off == LAST_OFF);

    cfs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (ph != PH_IDLE),
        .lim    (lim),
        .expire (expire)
    );

    cfs_slot_mux #(.NDEV(NDEV)) u_mux (
        .pos   (pos),
        .mode  (mode_q),
        .words (words_q),
        .bit_o (slot_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            mode_q  <= MD_SELF;
            words_q <= '0;
            half_q  <= HALF_FLOOR;
            load_q  <= LOAD_FLOOR;
            pos     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        mode_q  <= mode_in;
                        words_q <= words;
                        half_q  <= half_eff;
                        load_q  <= load_eff;
                        pos.grp <= '0;
                        pos.off <= has_marker(mode_in) ? OFF_W'(0) : OFF_W'(1);
                        ph      <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (expire) ph <= PH_HIGH;
                end
                PH_HIGH: begin
                    if (expire) begin
                        if (last_slot) begin
                            if (needs_strobe(mode_q)) begin
                                ph <= PH_LOAD;
                            end else begin
                                ph     <= PH_IDLE;
                                done_q <= 1'b1;
                            end
                        end else begin
                            ph <= PH_LOW;
                            if (pos.off == LAST_OFF) begin
                                pos.off <= '0;
                                pos.grp <= pos.grp + 1'b1;
                            end else begin
                                pos.off <= pos.off + 1'b1;
                            end
                        end
                    end
                end
                PH_LOAD: begin
                    if (expire) begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign ser_clk  = (ph == PH_HIGH);
    assign ser_load = (ph == PH_LOAD);
    assign ser_dat  = ((ph == PH_LOW) || (ph == PH_HIGH)) && slot_bit;
    assign busy     = (ph != PH_IDLE);
    assign done     = done_q;

    // R5
    dat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    // R6
    load_ends_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_load) |-> done);

    // R7
    self_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q == MD_SELF) |-> !ser_load);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(words_q) && $stable(mode_q)));

endmodule

// File: tb/cascade_frame_tx_bench.sv
module drv_model (
    input  logic        por,
    input  logic        sck,
    input  logic        din,
    input  logic        ld,
    output logic        dout,
    output logic [32:0] lat
);
    logic [33:0] sr;
    always @(posedge sck or posedge ld or posedge por) begin
        if (por) begin
            sr  <= '0;
            lat <= '0;
        end else if (ld) begin
            lat <= sr[32:0];
            sr  <= '0;
        end else begin
            sr <= {sr[32:0], din};
        end
    end
    assign dout = sr[33];
endmodule

module cascade_frame_tx_bench;
    localparam int N    = 3;
    localparam int CW   = 8;
    localparam int MINH = 2;
    localparam int MINL = 2;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [N*33-1:0] words = '0;
    logic [CW-1:0] half_div = 8'd2;
    logic [CW-1:0] load_len = 8'd2;
    logic ser_clk, ser_dat, ser_load, busy, done;
    logic self_md = 1'b0;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    cascade_frame_tx #(.NDEV(N), .CNT_W(CW), .MIN_HALF(MINH), .MIN_LOAD(MINL)) u_cascade_frame_tx (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .words(words),
        .half_div(half_div), .load_len(load_len), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_load(ser_load), .busy(busy), .done(done)
    );

    wire [N:0]  link;
    wire [32:0] lat [N];
    wire        ld_net = self_md ? link[N] : ser_load;
    assign link[0] = ser_dat;

    for (genvar d = 0; d < N; d++) begin : g_dev
        drv_model u_m (.por(rst), .sck(ser_clk), .din(link[d]), .ld(ld_net),
                       .dout(link[d+1]), .lat(lat[d]));
    end

    // stream capture and cycle totals
    logic cap [0:2047];
    int cap_n = 0;
    int rise_in_load = 0;
    always @(posedge ser_clk) begin
        if (cap_n < 2048) cap[cap_n] <= ser_dat;
        cap_n <= cap_n + 1;
        if (ser_load) rise_in_load <= rise_in_load + 1;
    end

    int hi_tot = 0, ld_tot = 0, busy_tot = 0, done_tot = 0, hold_bad = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0;
    always @(posedge clk) begin
        if (ser_clk)  hi_tot   <= hi_tot + 1;
        if (ser_load) ld_tot   <= ld_tot + 1;
        if (busy)     busy_tot <= busy_tot + 1;
        if (done)     done_tot <= done_tot + 1;
        if (ser_clk && prev_clk && ser_dat != prev_dat) hold_bad <= hold_bad + 1;
        prev_clk <= ser_clk;
        prev_dat <= ser_dat;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        // R1
        chk(ser_clk == 0 && ser_dat == 0 && ser_load == 0, "R1", "serial pins after reset",
            {ser_clk, ser_dat, ser_load}, 0);
        chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    endtask

    // Runs one frame; optionally pokes a second start with other data mid-frame.
    task automatic run_frame(input logic [1:0] m, input logic [N*33-1:0] w,
                             input int h, input int l, input bit poke);
        int base_cap, base_hi, base_ld, base_busy, base_done, base_rise, base_hold;
        int heff, leff, len, bad, n, wait_n;
        bit ext, exp_s [0:127];
        heff = (h < MINH) ? MINH : h;
        leff = (l < MINL) ? MINL : l;
        ext  = (m != 2'd0);
        len  = (m >= 2'd2) ? 34*N - 1 : 34*N;
        // expected stream from R2/R3/R4
        n = 0;
        for (int g = 0; g < N; g++) begin
            if (g == 0) begin
                if (m < 2'd2) begin exp_s[n] = 1'b1; n++; end
            end else begin
                exp_s[n] = (m == 2'd0); n++;
            end
            for (int b = 32; b >= 0; b--) begin
                exp_s[n] = w[(N-1-g)*33 + b]; n++;
            end
        end
        @(negedge clk);
        self_md   = (m == 2'd0);
        base_cap  = cap_n;   base_hi   = hi_tot;  base_ld = ld_tot;
        base_busy = busy_tot; base_done = done_tot; base_rise = rise_in_load;
        base_hold = hold_bad;
        mode = m; words = w; half_div = CW'(h); load_len = CW'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            mode = 2'd1; words = ~w; half_div = 8'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(wait_n < 20000, "R8", "done reached", wait_n, 0);
        @(negedge clk);
        // R3 R4: length of frame
        chk(cap_n - base_cap == len, m < 2 ? "R3" : "R4", "frame bit count", cap_n - base_cap, len);
        bad = 0;
        for (int i = 0; i < len; i++) if (cap[base_cap + i] != exp_s[i]) bad++;
        // R2 ordering, R4 separator value
        chk(bad == 0, "R2/R4", "stream bit mismatches", bad, 0);
        // R10
        for (int d = 0; d < N; d++)
            chk(lat[d] == w[d*33 +: 33], "R10", $sformatf("device %0d latch", d), lat[d], w[d*33 +: 33]);
        // R5
        chk(hi_tot - base_hi == len*heff, "R5", "high-phase cycles", hi_tot - base_hi, len*heff);
        chk(hold_bad == base_hold, "R5", "data change in high phase", hold_bad - base_hold, 0);
        if (ext) begin
            // R6
            chk(ld_tot - base_ld == leff, "R6", "strobe width", ld_tot - base_ld, leff);
            chk(rise_in_load == base_rise, "R6", "clock rise during strobe", rise_in_load - base_rise, 0);
        end else begin
            // R7
            chk(ld_tot == base_ld, "R7", "strobe in self-load", ld_tot - base_ld, 0);
        end
        // R8
        chk(busy_tot - base_busy == len*2*heff + (ext ? leff : 0), "R8", "busy cycles",
            busy_tot - base_busy, len*2*heff + (ext ? leff : 0));
        chk(done_tot - base_done == 1, poke ? "R9" : "R8", "done pulses", done_tot - base_done, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            // R9: the ignored start must not open a new frame
            chk(busy == 0 && cap_n - base_cap == len, "R9", "idle after ignored start",
                cap_n - base_cap, len);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1 rst = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        check_reset();
        run_frame(2'd0, {33'h1_2345_6789, 33'h0_F0F0_A5A5, 33'h1_8000_0001}, 3, 4, 1'b0);
        run_frame(2'd1, {33'h0_DEAD_BEEF, 33'h1_5555_5555, 33'h0_0000_0F01}, 2, 3, 1'b0);
        run_frame(2'd2, {33'h1_FFFF_FFFF, 33'h1_FFFF_FFFF, 33'h1_FFFF_FFFF}, 1, 0, 1'b0);
        run_frame(2'd3, {33'h0_1357_9BDF, 33'h1_2468_ACE0, 33'h0_AAAA_0001}, 4, 5, 1'b0);
        run_frame(2'd0, {33'h1_0000_0000, 33'h0_7777_3333, 33'h1_CAFE_0042}, 2, 2, 1'b1);
        run_frame(2'd1, {33'h1_FFFF_FFFF, 33'h0_0000_0000, 33'h1_FFFF_FFFF}, 2, 6, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule